// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register storage of a processor core that runs in several privilege modes. Software always sees sixteen 32-bit registers, indexed 0 to 15, but the block keeps thirty-one physical registers. On each access the current mode selects which physical copy an index names. Exception handlers therefore get private stack pointer and link registers without any save or restore. Fast interrupt handlers also get private working registers for indices 8 to 12.

There are two read ports, which are combinational, and one write port, which commits on the rising clock edge. All three ports share one mode input. A force-user input sends every port to the user copies whatever the mode is. This is how a privileged handler reaches the registers of the interrupted user program. Index 15 holds the program counter, and every mode uses the same copy of it.

The block has no state machine. Its mode-to-bank decoder is a pure case selection over the mode encodings. Each port has its own index mapper, and the mappers are built by a generate loop.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted, and at once after it is released, every index in every mode reads 0.
- R2: Mode codes 10000 (user), 11111 (system) and any code not listed in R3 or R4 all select the user registers for all sixteen indices.
- R3: Mode code 10001 (fast interrupt) selects private copies of indices 8 to 14. Indices 0 to 7 and 15 are the user copies.
- R4: Mode codes 10010 (interrupt), 10011 (supervisor), 10111 (abort) and 11011 (undefined) each select their own private copies of indices 13 and 14. Indices 0 to 12 and 15 are the user copies. The four modes share no private copy with each other.
- R5: When force-user is high, the reads and the write address the user copies, whatever the mode code is.
- R6: A write with the enable high stores its data at the rising edge. A read of the same physical register in the same cycle returns the value it held before the write, with no bypass.
- R7: When the write enable is low, no register changes, whatever is on the write index and write data inputs.
- R8: The two read ports work independently. Each returns the register its own index selects, in the same cycle.
- R9: Index 15 names one physical register in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| mode_i | input | 5 | Current processor mode code |
| force_user_i | input | 1 | Sends all ports to the user copies |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 32 | Write data |

## Verification
The assertions assume that the mode, force-user, index and enable inputs are driven to known values at every rising edge after reset. They also assume that these inputs change only between edges, so the mapped physical indices are settled when they are sampled. The bench meets this by changing every input on the falling edge and holding it for a whole cycle. It samples the read data two nanoseconds later, before the write of that cycle commits. It leaves the write enable low on any cycle where the write data is only filler.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int XLEN     = 32;
    localparam int AIDX_W   = 4;
    localparam int MODE_W   = 5;
    localparam int NUM_ARCH = 1 << AIDX_W;
    localparam int NUM_PHYS = 31;
    localparam int PIDX_W   = $clog2(NUM_PHYS);

    typedef logic [AIDX_W-1:0] aidx_t;
    typedef logic [PIDX_W-1:0] pidx_t;
    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_USR = 5'b10000;
    localparam mode_t MODE_FIQ = 5'b10001;
    localparam mode_t MODE_IRQ = 5'b10010;
    localparam mode_t MODE_SVC = 5'b10011;
    localparam mode_t MODE_ABT = 5'b10111;
    localparam mode_t MODE_UND = 5'b11011;
    localparam mode_t MODE_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BANK_USR,
        BANK_FIQ,
        BANK_IRQ,
        BANK_SVC,
        BANK_ABT,
        BANK_UND
    } bank_e;

    // Banked index windows
    localparam int FIQ_LO  = 8;
    localparam int FIQ_HI  = 14;
    localparam int PAIR_LO = 13;
    localparam int PAIR_HI = 14;
    localparam int FIQ_CNT  = FIQ_HI - FIQ_LO + 1;
    localparam int PAIR_CNT = PAIR_HI - PAIR_LO + 1;

    // Physical layout: user copies first, then the fast interrupt
    // window, then one pair per remaining exception mode.
    localparam int FIQ_BASE = NUM_ARCH;
    localparam int IRQ_BASE = FIQ_BASE + FIQ_CNT;
    localparam int SVC_BASE = IRQ_BASE + PAIR_CNT;
    localparam int ABT_BASE = SVC_BASE + PAIR_CNT;
    localparam int UND_BASE = ABT_BASE + PAIR_CNT;

    localparam int PC_IDX = NUM_ARCH - 1;

endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_i,
    input  logic  force_user_i,
    output bank_e bank_o
);

    bank_e bank_by_mode;

    always_comb begin
        unique case (mode_i)
            MODE_FIQ: bank_by_mode = BANK_FIQ;
            MODE_IRQ: bank_by_mode = BANK_IRQ;
            MODE_SVC: bank_by_mode = BANK_SVC;
            MODE_ABT: bank_by_mode = BANK_ABT;
            MODE_UND: bank_by_mode = BANK_UND;
            default:  bank_by_mode = BANK_USR;
        endcase
    end

    always_comb begin
        bank_o = force_user_i ? BANK_USR : bank_by_mode;
    end

    p_force_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_user_i |-> bank_o == BANK_USR);

    p_sys_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SYS) |-> bank_o == BANK_USR);

endmodule

// File: rtl/phys_map.sv
module phys_map
    import bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  aidx_t arch_i,
    input  bank_e bank_i,
    output pidx_t phys_o
);

    logic  in_fiq_win;
    logic  in_pair_win;
    pidx_t pair_base;
    pidx_t arch_ext;

    assign arch_ext = pidx_t'(arch_i);

    always_comb begin
        in_fiq_win  = (int'(arch_i) >= FIQ_LO)  && (int'(arch_i) <= FIQ_HI);
        in_pair_win = (int'(arch_i) >= PAIR_LO) && (int'(arch_i) <= PAIR_HI);
    end

    always_comb begin
        unique case (bank_i)
            BANK_IRQ: pair_base = pidx_t'(IRQ_BASE);
            BANK_SVC: pair_base = pidx_t'(SVC_BASE);
            BANK_ABT: pair_base = pidx_t'(ABT_BASE);
            BANK_UND: pair_base = pidx_t'(UND_BASE);
            default:  pair_base = '0;
        endcase
    end

    always_comb begin
        phys_o = arch_ext;
        if (bank_i == BANK_FIQ) begin
            if (in_fiq_win)
                phys_o = pidx_t'(FIQ_BASE) + arch_ext - pidx_t'(FIQ_LO);
        end else if (bank_i != BANK_USR) begin
            if (in_pair_win)
                phys_o = pair_base + arch_ext - pidx_t'(PAIR_LO);
        end
    end

    p_pc_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arch_i) == PC_IDX) |-> (int'(phys_o) == PC_IDX));

    p_low_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arch_i) < FIQ_LO) |-> (phys_o == arch_ext));

    p_pair_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_i != BANK_FIQ && int'(arch_i) < PAIR_LO) |-> (phys_o == arch_ext));

    p_user_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_i == BANK_USR) |-> (phys_o == arch_ext));

    p_phys_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phys_o) < NUM_PHYS);

endmodule

// File: rtl/reg_store.sv
module reg_store
    import bank_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int DEPTH  = NUM_PHYS,
    parameter int NRD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  pidx_t             wr_phys_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  pidx_t             rd_phys_i [NRD],
    output logic [DATA_W-1:0] rd_data_o [NRD]
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '0;
        end else if (wr_en_i) begin
            cells[wr_phys_i] <= wr_data_i;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data_o[p] = cells[rd_phys_i[p]];
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              force_user_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;
    localparam int WR_P  = NRD;

    bank_e             bank;
    aidx_t             port_arch [NPORT];
    pidx_t             port_phys [NPORT];
    pidx_t             rd_phys   [NRD];
    logic [DATA_W-1:0] rd_data   [NRD];
    logic              past_ok;

    assign port_arch[0]    = rd_a_idx_i;
    assign port_arch[1]    = rd_b_idx_i;
    assign port_arch[WR_P] = wr_idx_i;

    bank_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .force_user_i (force_user_i),
        .bank_o       (bank)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        phys_map u_map (
            .clk    (clk),
            .rst_n  (rst_n),
            .arch_i (port_arch[p]),
            .bank_i (bank),
            .phys_o (port_phys[p])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rdsel
        assign rd_phys[p] = port_phys[p];
    end

    reg_store #(
        .DATA_W (DATA_W),
        .DEPTH  (NUM_PHYS),
        .NRD    (NRD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_phys_i (port_phys[WR_P]),
        .wr_data_i (wr_data_i),
        .rd_phys_i (rd_phys),
        .rd_data_o (rd_data)
    );

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];

    // Marks that one full cycle out of reset has been sampled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_write_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en_i) && rd_phys[0] == $past(port_phys[WR_P]))
        |-> rd_a_data_o == $past(wr_data_i));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_en_i) && rd_phys[0] == $past(rd_phys[0]))
        |-> rd_a_data_o == $past(rd_a_data_o));

    p_ports_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phys[0] == rd_phys[1]) |-> rd_a_data_o == rd_b_data_o);

endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

    localparam int DW = 32;
    localparam time HALF = 10ns;

    typedef struct packed {
        logic [4:0]    mode;
        logic          fu;
        logic          we;
        logic [3:0]    widx;
        logic [DW-1:0] wdata;
        logic [3:0]    ra;
        logic [3:0]    rb;
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
    } vec_t;

    localparam int NV = 20;

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111, BAD = 5'b10100;

    // Reads are sampled before the write of the same row commits.
    localparam vec_t VECS [NV] = '{
        '{USR, 1'b0, 1'b1, 4'd13, 32'h1000_0013, 4'd13, 4'd14, 32'h0,          32'h0},          // R2
        '{USR, 1'b0, 1'b1, 4'd14, 32'h1000_0014, 4'd13, 4'd14, 32'h1000_0013, 32'h0},          // R6 old value
        '{FIQ, 1'b0, 1'b1, 4'd13, 32'hF000_0013, 4'd13, 4'd14, 32'h0,          32'h0},          // R3
        '{FIQ, 1'b0, 1'b1, 4'd8,  32'hF000_0008, 4'd13, 4'd8,  32'hF000_0013, 32'h0},          // R3
        '{USR, 1'b0, 1'b1, 4'd8,  32'h1000_0008, 4'd13, 4'd8,  32'h1000_0013, 32'h0},          // R3
        '{IRQ, 1'b0, 1'b1, 4'd13, 32'h2000_0013, 4'd8,  4'd13, 32'h1000_0008, 32'h0},          // R4
        '{SVC, 1'b0, 1'b1, 4'd13, 32'h3000_0013, 4'd13, 4'd14, 32'h0,          32'h0},          // R4
        '{ABT, 1'b0, 1'b1, 4'd14, 32'h4000_0014, 4'd13, 4'd14, 32'h0,          32'h0},          // R4
        '{UND, 1'b0, 1'b1, 4'd15, 32'h0000_8000, 4'd13, 4'd14, 32'h0,          32'h0},          // R4
        '{FIQ, 1'b0, 1'b0, 4'd0,  32'hDEAD_BEEF, 4'd15, 4'd8,  32'h0000_8000, 32'hF000_0008}, // R9 R7
        '{SYS, 1'b0, 1'b0, 4'd0,  32'hDEAD_BEEF, 4'd13, 4'd14, 32'h1000_0013, 32'h1000_0014}, // R2
        '{FIQ, 1'b1, 1'b0, 4'd0,  32'hDEAD_BEEF, 4'd13, 4'd8,  32'h1000_0013, 32'h1000_0008}, // R5
        '{BAD, 1'b0, 1'b0, 4'd0,  32'hDEAD_BEEF, 4'd13, 4'd15, 32'h1000_0013, 32'h0000_8000}, // R2 R9
        '{IRQ, 1'b0, 1'b0, 4'd0,  32'h0,         4'd13, 4'd14, 32'h2000_0013, 32'h0},          // R4
        '{SVC, 1'b0, 1'b0, 4'd0,  32'h0,         4'd13, 4'd14, 32'h3000_0013, 32'h0},          // R4
        '{ABT, 1'b0, 1'b0, 4'd0,  32'h0,         4'd13, 4'd14, 32'h0,          32'h4000_0014}, // R4
        '{FIQ, 1'b1, 1'b1, 4'd14, 32'h5000_0014, 4'd14, 4'd14, 32'h1000_0014, 32'h1000_0014}, // R5 R8
        '{USR, 1'b0, 1'b0, 4'd0,  32'h0,         4'd14, 4'd13, 32'h5000_0014, 32'h1000_0013}, // R5
        '{FIQ, 1'b0, 1'b0, 4'd0,  32'h0,         4'd14, 4'd13, 32'h0,          32'hF000_0013}, // R5
        '{USR, 1'b0, 1'b0, 4'd0,  32'h0,         4'd0,  4'd15, 32'h0,          32'h0000_8000}  // R7 R9
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    mode = 5'b10000;
    logic          fu = 1'b0;
    logic [3:0]    ra = '0, rb = '0, widx = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] da, db;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(HALF) clk = ~clk;

    banked_regfile uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .force_user_i (fu),
        .rd_a_idx_i   (ra),
        .rd_a_data_o  (da),
        .rd_b_idx_i   (rb),
        .rd_b_data_o  (db),
        .wr_en_i      (we),
        .wr_idx_i     (widx),
        .wr_data_i    (wdata)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: every index reads zero during and right after reset
        repeat (2) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            ra = 4'(i); rb = 4'(15 - i);
            #2;
            chk("R1 reset port A", da, '0);
            chk("R1 reset port B", db, '0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mode = FIQ; ra = 4'd9; rb = 4'd13;
        #2;
        chk("R1 after release FIQ A", da, '0);
        chk("R1 after release FIQ B", db, '0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mode = VECS[v].mode; fu = VECS[v].fu; we = VECS[v].we;
            widx = VECS[v].widx; wdata = VECS[v].wdata;
            ra = VECS[v].ra; rb = VECS[v].rb;
            #2;
            chk($sformatf("R2-R9 table row %0d port A", v), da, VECS[v].ea);
            chk($sformatf("R8 table row %0d port B", v), db, VECS[v].eb);
        end

        // R6: write then read back on the next cycle
        @(negedge clk);
        mode = UND; fu = 1'b0; we = 1'b1; widx = 4'd14; wdata = 32'h6000_0014;
        ra = 4'd14; rb = 4'd14;
        #2;
        chk("R6 same cycle old", da, '0);
        @(negedge clk);
        we = 1'b0;
        #2;
        chk("R6 next cycle new", da, 32'h6000_0014);
        chk("R8 next cycle port B", db, 32'h6000_0014);

        // R7: disabled write of every index in fast interrupt mode
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            mode = FIQ; we = 1'b0; widx = 4'(i); wdata = 32'hBAD0_0000 | 32'(i);
        end
        @(negedge clk);
        ra = 4'd8; rb = 4'd15;
        #2;
        chk("R7 FIQ r8 kept", da, 32'hF000_0008);
        chk("R7 r15 kept", db, 32'h0000_8000);

        // R1: reset in the middle of operation clears banked copies
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; mode = IRQ; ra = 4'd13; rb = 4'd8;
        #2;
        chk("R1 mid-run IRQ r13", da, '0);
        chk("R1 mid-run r8", db, '0);

        finish_run();
    end

endmodule